// File: doc/BRIEF.md
# Split-Word Host Mailbox Registers

This block holds two 64-bit mailboxes that a processor reaches over a 32-bit register bus. The outgoing mailbox carries commands from the processor to a command engine. The incoming mailbox carries responses back to the processor. The bus moves one 32-bit word per access, so each mailbox takes two word addresses: the low half at the mailbox address and the high half four bytes above it. The processor writes the low half first and the high half second.

The outgoing mailbox takes new work only when it is empty, meaning it reads as zero. A low-half write to an empty mailbox arms the block. The high-half write that follows completes the 64-bit command, and the block shows it to the engine for one cycle on a command strobe. When the engine finishes, it empties the outgoing mailbox. In the same cycle it may also load a 64-bit response into the incoming mailbox.

The host side fills the incoming mailbox over the bus in the same two steps. An in-progress output is high between the low-half write and the high-half write. The two mailbox addresses are parameters. The decoded window starts at the lower of the two and ends eight bytes past the higher.

Top module: `hostmbox_top`

## Requirements
- R1: After reset both mailboxes read zero, the arm flag and the in-progress output are low, and no command strobe, miss pulse or nonzero read data appears.
- R2: A write to the outgoing low half (address OUT_ADDR) while the whole outgoing mailbox is zero loads bits 31:0 with the write data, clears bits 63:32 and sets the arm flag.
- R3: A write to the outgoing low half while the outgoing mailbox is nonzero leaves the mailbox unchanged and clears the arm flag. A high-half write that follows it issues no command.
- R4: A write to the outgoing high half (OUT_ADDR+4) while armed ORs the data into bits 63:32. In the next cycle cmd_valid_o is high for exactly one cycle, and cmd_word_o carries the full 64-bit word. The arm flag stays set, so a further high-half write ORs in again and issues another command. While disarmed, a high-half write changes nothing.
- R5: A write to the incoming low half (IN_ADDR) loads bits 31:0, clears bits 63:32 and drives inbox_filling_o high. A write to the incoming high half (IN_ADDR+4) ORs the data into bits 63:32 and drives inbox_filling_o low.
- R6: A read returns, in the cycle after the request, the matching 32 bits: low half at the mailbox address, high half at the address plus 4.
- R7: A read or write to any address other than those four word addresses, misaligned ones included, returns zero, raises bus_miss_o for one cycle in the next cycle and changes no state.
- R8: eng_done_i clears the outgoing mailbox to zero and takes priority over a bus write to the outgoing mailbox in the same cycle. It leaves the arm flag as the bus write sets it.
- R9: eng_done_i together with eng_resp_valid_i loads eng_resp_i into the incoming mailbox and drives inbox_filling_o low. This load takes priority over a bus write to the incoming mailbox in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write request |
| bus_rd_i | input | 1 | Register read request |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after bus_rd_i |
| bus_miss_o | output | 1 | One-cycle pulse after an access to an unmapped address |
| cmd_valid_o | output | 1 | One-cycle command strobe to the engine |
| cmd_word_o | output | 64 | Assembled command word, valid with cmd_valid_o |
| eng_done_i | input | 1 | Engine finished; empties the outgoing mailbox |
| eng_resp_valid_i | input | 1 | Response present with eng_done_i |
| eng_resp_i | input | 64 | Response word for the incoming mailbox |
| inbox_filling_o | output | 1 | Incoming mailbox is half written |

## Verification
A wrong arm flag does not show at the ports right away. It shows only when a high-half write either issues a command strobe it should not, or fails to issue one it should. The bench therefore follows each rejected low-half write with a high-half write. A mailbox half that is merged or cleared wrongly shows as wrong read data one cycle after the read that selects it. A wrong priority between the engine and the bus shows on the first read of the mailbox after the collision. A reference model, compared on every clock, catches these through directed collisions and a random stream of mixed accesses.

// File: rtl/hostmbox_pkg.sv
package hostmbox_pkg;
    localparam int WORD_W = 32;
    localparam int MBOX_W = 2 * WORD_W;
    localparam int NUM_SLOTS = 4;

    // Slot order: the two halves of each mailbox sit 4 bytes apart.
    typedef enum logic [1:0] {
        SLOT_OUT_LO = 2'd0,
        SLOT_OUT_HI = 2'd1,
        SLOT_IN_LO  = 2'd2,
        SLOT_IN_HI  = 2'd3
    } slot_e;

    typedef struct packed {
        logic [MBOX_W-1:0] outbox;
        logic [MBOX_W-1:0] inbox;
        logic              armed;
        logic              filling;
        logic [WORD_W-1:0] rdata;
        logic              miss;
        logic              cmd_v;
        logic [MBOX_W-1:0] cmd_w;
    } mbox_state_t;
endpackage

// File: rtl/hostmbox_decode.sv
module hostmbox_decode
    import hostmbox_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int OUT_ADDR = 'h108,
    parameter int IN_ADDR  = 'h100
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_SLOTS-1:0] slot_hit_o
);
    localparam int BASE    = (OUT_ADDR < IN_ADDR) ? OUT_ADDR : IN_ADDR;
    localparam int TOP     = (OUT_ADDR < IN_ADDR) ? IN_ADDR : OUT_ADDR;
    localparam int SPAN    = TOP + 8 - BASE;
    localparam int OUT_OFF = OUT_ADDR - BASE;
    localparam int IN_OFF  = IN_ADDR - BASE;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

    logic [ADDR_W-1:0] offset;
    assign offset = addr_i - BASE_A;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam int SLOT_OFF = ((g < 2) ? OUT_OFF : IN_OFF) + 4 * (g % 2);
        localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_OFF);
        assign slot_hit_o[g] = (offset == SLOT_A) && (SLOT_OFF < SPAN);
    end
endmodule

// File: rtl/hostmbox_regs.sv
module hostmbox_regs
    import hostmbox_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic [NUM_SLOTS-1:0] slot_hit_i,
    input  logic                 eng_done_i,
    input  logic                 eng_resp_valid_i,
    input  logic [MBOX_W-1:0]    eng_resp_i,
    output logic [WORD_W-1:0]    rdata_o,
    output logic                 miss_o,
    output logic                 cmd_valid_o,
    output logic [MBOX_W-1:0]    cmd_word_o,
    output logic                 filling_o
);
    mbox_state_t st_d, st_q;
    logic any_hit, access, resp_load;

    assign any_hit   = |slot_hit_i;
    assign access    = wr_i | rd_i;
    assign resp_load = eng_done_i & eng_resp_valid_i;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.miss  = access & ~any_hit;
        st_d.cmd_v = 1'b0;

        if (rd_i) begin
            if (slot_hit_i[SLOT_OUT_LO]) st_d.rdata = st_q.outbox[WORD_W-1:0];
            if (slot_hit_i[SLOT_OUT_HI]) st_d.rdata = st_q.outbox[MBOX_W-1:WORD_W];
            if (slot_hit_i[SLOT_IN_LO])  st_d.rdata = st_q.inbox[WORD_W-1:0];
            if (slot_hit_i[SLOT_IN_HI])  st_d.rdata = st_q.inbox[MBOX_W-1:WORD_W];
        end

        if (wr_i) begin
            if (slot_hit_i[SLOT_OUT_LO]) begin
                if (st_q.outbox == '0) begin
                    st_d.outbox = {{WORD_W{1'b0}}, wdata_i};
                    st_d.armed  = 1'b1;
                end else begin
                    st_d.armed  = 1'b0;
                end
            end
            if (slot_hit_i[SLOT_OUT_HI] && st_q.armed) begin
                st_d.outbox[MBOX_W-1:WORD_W] = st_q.outbox[MBOX_W-1:WORD_W] | wdata_i;
                st_d.cmd_v = 1'b1;
                st_d.cmd_w = {st_q.outbox[MBOX_W-1:WORD_W] | wdata_i,
                              st_q.outbox[WORD_W-1:0]};
            end
            if (slot_hit_i[SLOT_IN_LO]) begin
                st_d.inbox   = {{WORD_W{1'b0}}, wdata_i};
                st_d.filling = 1'b1;
            end
            if (slot_hit_i[SLOT_IN_HI]) begin
                st_d.inbox[MBOX_W-1:WORD_W] = st_q.inbox[MBOX_W-1:WORD_W] | wdata_i;
                st_d.filling = 1'b0;
            end
        end

        if (eng_done_i) begin
            st_d.outbox = '0;
            if (resp_load) begin
                st_d.inbox   = eng_resp_i;
                st_d.filling = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o     = st_q.rdata;
    assign miss_o      = st_q.miss;
    assign cmd_valid_o = st_q.cmd_v;
    assign cmd_word_o  = st_q.cmd_w;
    assign filling_o   = st_q.filling;

    // R4
    cmd_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(st_q.armed));

    // R3
    reject_keeps_box_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && slot_hit_i[SLOT_OUT_LO] && st_q.outbox != '0 && !eng_done_i)
        |=> ($stable(st_q.outbox) && !st_q.armed));

    // R7
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (rdata_o == '0));

    // R8
    done_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done_i |=> (st_q.outbox == '0));

    // R5
    high_ends_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && slot_hit_i[SLOT_IN_HI]) |=> !filling_o);

    // R7
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit_i));
endmodule

// File: rtl/hostmbox_top.sv
module hostmbox_top
    import hostmbox_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int OUT_ADDR = 'h108,
    parameter int IN_ADDR  = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              bus_miss_o,
    output logic              cmd_valid_o,
    output logic [63:0]       cmd_word_o,
    input  logic              eng_done_i,
    input  logic              eng_resp_valid_i,
    input  logic [63:0]       eng_resp_i,
    output logic              inbox_filling_o
);
    logic [NUM_SLOTS-1:0] slot_hit;

    hostmbox_decode #(
        .ADDR_W  (ADDR_W),
        .OUT_ADDR(OUT_ADDR),
        .IN_ADDR (IN_ADDR)
    ) u_decode (
        .addr_i    (bus_addr_i),
        .slot_hit_o(slot_hit)
    );

    hostmbox_regs u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_i            (bus_wr_i),
        .rd_i            (bus_rd_i),
        .wdata_i         (bus_wdata_i),
        .slot_hit_i      (slot_hit),
        .eng_done_i      (eng_done_i),
        .eng_resp_valid_i(eng_resp_valid_i),
        .eng_resp_i      (eng_resp_i),
        .rdata_o         (bus_rdata_o),
        .miss_o          (bus_miss_o),
        .cmd_valid_o     (cmd_valid_o),
        .cmd_word_o      (cmd_word_o),
        .filling_o       (inbox_filling_o)
    );
endmodule

// File: tb/sim_hostmbox_top.sv
module sim_hostmbox_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam logic [AW-1:0] OLO = 12'h108, OHI = 12'h10C, ILO = 12'h100, IHI = 12'h104;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic bus_miss, cmd_valid, filling;
    logic [63:0] cmd_word;
    logic eng_done = 1'b0, eng_rv = 1'b0;
    logic [63:0] eng_resp = '0;

    int checks = 0, errors = 0;
    bit live = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostmbox_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .bus_miss_o(bus_miss), .cmd_valid_o(cmd_valid), .cmd_word_o(cmd_word),
        .eng_done_i(eng_done), .eng_resp_valid_i(eng_rv), .eng_resp_i(eng_resp),
        .inbox_filling_o(filling)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [63:0] m_out = '0, m_in = '0, m_cw = '0;
    logic m_arm = 0, m_fill = 0, m_miss = 0, m_cv = 0;
    logic [31:0] m_rd = '0;

    always @(posedge clk) begin
        logic [63:0] n_out, n_in;
        logic n_arm, n_fill;
        if (!rst_n) begin
            m_out = '0; m_in = '0; m_arm = 0; m_fill = 0; m_rd = '0; m_miss = 0; m_cv = 0;
        end else begin
            n_out = m_out; n_in = m_in; n_arm = m_arm; n_fill = m_fill;
            m_rd = '0; m_cv = 0;
            m_miss = (bus_wr || bus_rd) &&
                     !(bus_addr == OLO || bus_addr == OHI || bus_addr == ILO || bus_addr == IHI);
            if (bus_rd) begin
                if (bus_addr == OLO) m_rd = m_out[31:0];
                else if (bus_addr == OHI) m_rd = m_out[63:32];
                else if (bus_addr == ILO) m_rd = m_in[31:0];
                else if (bus_addr == IHI) m_rd = m_in[63:32];
            end
            if (bus_wr) begin
                if (bus_addr == OLO) begin
                    if (m_out == 0) begin n_out = {32'h0, bus_wdata}; n_arm = 1; end
                    else n_arm = 0;
                end else if (bus_addr == OHI && m_arm) begin
                    n_out = {m_out[63:32] | bus_wdata, m_out[31:0]};
                    m_cv = 1; m_cw = n_out;
                end else if (bus_addr == ILO) begin
                    n_in = {32'h0, bus_wdata}; n_fill = 1;
                end else if (bus_addr == IHI) begin
                    n_in = {m_in[63:32] | bus_wdata, m_in[31:0]}; n_fill = 0;
                end
            end
            if (eng_done) begin
                n_out = '0;
                if (eng_rv) begin n_in = eng_resp; n_fill = 0; end
            end
            m_out = n_out; m_in = n_in; m_arm = n_arm; m_fill = n_fill;
        end
    end

    always @(negedge clk) begin
        if (live) begin
            chk("R6 rdata", {32'h0, bus_rdata}, {32'h0, m_rd});
            chk("R7 miss", {63'h0, bus_miss}, {63'h0, m_miss});
            chk("R4 cmd_valid", {63'h0, cmd_valid}, {63'h0, m_cv});
            if (m_cv) chk("R4 cmd_word", cmd_word, m_cw);
            chk("R5 filling", {63'h0, filling}, {63'h0, m_fill});
        end
    end

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        live = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 filling", {63'h0, filling}, 64'h0);
        chk("R1 cmd_valid", {63'h0, cmd_valid}, 64'h0);
        rd(OLO, v); chk("R1 out lo", {32'h0, v}, 64'h0);
        rd(IHI, v); chk("R1 in hi", {32'h0, v}, 64'h0);

        // R2 accepted low write
        wr(OLO, 32'h11223344);
        rd(OLO, v); chk("R2 out lo", {32'h0, v}, 64'h11223344);
        rd(OHI, v); chk("R2 out hi", {32'h0, v}, 64'h0);

        // R4 high write completes command
        wr(OHI, 32'hA0B0C0D0);
        chk("R4 strobe", {63'h0, cmd_valid}, 64'h1);
        chk("R4 word", cmd_word, 64'hA0B0C0D0_11223344);
        @(negedge clk);
        chk("R4 one cycle", {63'h0, cmd_valid}, 64'h0);

        // R3 rejected low write disarms
        wr(OLO, 32'h5555);
        rd(OLO, v); chk("R3 out lo kept", {32'h0, v}, 64'h11223344);
        wr(OHI, 32'h0F);
        chk("R3 no strobe", {63'h0, cmd_valid}, 64'h0);
        rd(OHI, v); chk("R3 out hi kept", {32'h0, v}, 64'hA0B0C0D0);

        // R8 and R9 engine completion with response
        eng_done = 1; eng_rv = 1; eng_resp = 64'hDEADBEEF_01020304;
        @(negedge clk);
        eng_done = 0; eng_rv = 0;
        rd(OLO, v); chk("R8 out cleared", {32'h0, v}, 64'h0);
        rd(IHI, v); chk("R9 in hi", {32'h0, v}, 64'hDEADBEEF);

        // R5 incoming two-step fill
        wr(ILO, 32'h77);
        chk("R5 filling set", {63'h0, filling}, 64'h1);
        rd(IHI, v); chk("R5 hi cleared", {32'h0, v}, 64'h0);
        wr(IHI, 32'h12);
        chk("R5 filling clear", {63'h0, filling}, 64'h0);
        wr(IHI, 32'h21);
        rd(IHI, v); chk("R5 hi ored", {32'h0, v}, 64'h33);

        // R7 unmapped and misaligned
        rd(12'h110, v); chk("R7 rd zero", {32'h0, v}, 64'h0);
        chk("R7 miss pulse", {63'h0, bus_miss}, 64'h1);
        wr(12'h102, 32'hFFFFFFFF);
        chk("R7 miss wr", {63'h0, bus_miss}, 64'h1);
        rd(ILO, v); chk("R7 in lo intact", {32'h0, v}, 64'h77);
        rd(OLO, v); chk("R7 out intact", {32'h0, v}, 64'h0);

        // R4 re-issue while still armed
        wr(OLO, 32'h1);
        wr(OHI, 32'h2);
        wr(OHI, 32'h4);
        chk("R4 reissue", cmd_word, 64'h00000006_00000001);
        eng_done = 1; @(negedge clk); eng_done = 0;

        // R8 done beats same-cycle outgoing write
        eng_done = 1; wr(OLO, 32'h99); eng_done = 0;
        rd(OLO, v); chk("R8 priority", {32'h0, v}, 64'h0);

        // R9 response beats same-cycle incoming write
        eng_done = 1; eng_rv = 1; eng_resp = 64'h0000ABCD_00001234;
        wr(ILO, 32'h55);
        eng_done = 0; eng_rv = 0;
        rd(ILO, v); chk("R9 priority lo", {32'h0, v}, 64'h1234);
        chk("R9 filling", {63'h0, filling}, 64'h0);

        // Random mixed traffic compared against the model every clock
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 5);
            bus_addr = (sel == 0) ? OLO : (sel == 1) ? OHI : (sel == 2) ? ILO :
                       (sel == 3) ? IHI : (sel == 4) ? 12'h118 : 12'h109;
            bus_wdata = $urandom();
            bus_wr = ($urandom_range(0, 1) == 1);
            bus_rd = !bus_wr;
            eng_done = ($urandom_range(0, 7) == 0);
            eng_rv = ($urandom_range(0, 1) == 1);
            eng_resp = {$urandom(), $urandom()};
            @(negedge clk);
        end
        bus_wr = 0; bus_rd = 0; eng_done = 0; eng_rv = 0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule